// File: doc/BRIEF.md
# Dual-Channel High/Low Count PWM

This block produces two independent pulse-width-modulated outputs. Each channel picks one of four source strobes, divides it by a programmable factor and passes the result through an enable gate. Every surviving tick advances a counter that keeps the output high for a programmed number of ticks, then low for a second programmed number, and then starts again. The shape of the wave is set by these two lengths rather than by a period and a compare value. There is no polarity control: every period begins with its high part.

Software reaches the block over a small single-cycle register bus. There is one count word per channel. One control word is shared by both channels and holds, for each channel, the enable, the source select, the divider value and the tick gate. The source clocks are outside the block. They arrive as single-cycle strobes, synchronous to the system clock, that mark each source rising edge. A grounded source never strobes.

Top module: `dual_hl_pwm`

## Requirements
- R1: After a synchronous reset both outputs are low and all three registers read zero.
- R2: Reads return the selected register one cycle after the address is presented. The count words at 0x0 (channel A) and 0x4 (channel B) return exactly what was written. The control word at 0x8 returns bits 23:0 as written and zeros in bits 31:24.
- R3: A count word holds the low length in bits 15:0 and the high length in bits 31:16, in ticks. An enabled channel drives high for the high length and then low for the low length, repeating, with each period starting high. The output is never high while the channel's enable is clear.
- R4: Control word fields: bit 0 and bit 1 enable channels A and B. Bits 5:4 and 7:6 select their sources. Bits 14:8 and 22:16 hold their divider values. Bits 15 and 23 gate their ticks.
- R5: The source select value n takes strobe input n. Selecting an input that never strobes freezes the output at its current level.
- R6: A divider value d yields one tick per d+1 strobes of the selected source, so d=0 passes every strobe.
- R7: A high length of zero keeps the output low. A low length of zero keeps it high.
- R8: Clearing a channel's enable drives its output low on the clock edge after the register update, without waiting for the period to end.
- R9: A count word written while its channel runs takes effect at the next period boundary. A rising enable restarts the channel in its high part on the clock edge after the register update.
- R10: While a channel's gate bit is clear its output keeps its level. Setting the bit again resumes the wave.
- R11: The two channels run independently, each with its own settings.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| src_tick | input | NUM_SRC (4) | One-cycle strobes marking rising edges of the four source clocks |
| bus_wr | input | 1 | Write strobe; writes bus_wdata to bus_addr on this edge |
| bus_addr | input | ADDR_W (4) | Register byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data for the previous cycle's address |
| pwm_out | output | 2 | Registered wave outputs, bit 0 channel A, bit 1 channel B |

## Verification
A wrong phase flag or tick count inside a channel shows up at pwm_out within one period as a high or low run of the wrong length. The bench scoreboard measures every such run in clock cycles and compares it to the programmed count times the strobe spacing times the divider factor. A stale shadow count shows up as one period with the wrong shape right after a count write, so the boundary handover is measured period by period. A faulty enable, gate or restart path shows up within one or two clock edges of the control write, and the checks sample at exactly those edges.

// File: rtl/dhp_pkg.sv
package dhp_pkg;
  localparam int unsigned NUM_CH    = 2;
  localparam int unsigned DATA_W    = 32;
  localparam int unsigned CTRL_USED = 24;
  // control word layout, per channel c
  localparam int unsigned SEL_BASE  = 4;
  localparam int unsigned DIV_BASE  = 8;
  localparam int unsigned DIV_STEP  = 8;
  localparam int unsigned GATE_BASE = 15;
endpackage

// File: rtl/dhp_regs.sv
module dhp_regs #(
  parameter int unsigned ADDR_W    = 4,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned N_CH      = 2,
  parameter int unsigned CTRL_USED = 24
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           wr_en,
  input  logic [ADDR_W-1:0]              addr,
  input  logic [DATA_W-1:0]              wdata,
  output logic [DATA_W-1:0]              rdata,
  output logic [N_CH-1:0][DATA_W-1:0]    cnt_o,
  output logic [CTRL_USED-1:0]           ctrl_o
);
  localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(N_CH * 4);

  logic [N_CH-1:0][DATA_W-1:0] cnt_q;
  logic [CTRL_USED-1:0]        ctrl_q;
  logic [DATA_W-1:0]           rd_nx;

  always_comb begin
    rd_nx = '0;
    for (int i = 0; i < N_CH; i++)
      if (addr == ADDR_W'(i * 4)) rd_nx = cnt_q[i];
    if (addr == CTRL_ADDR) rd_nx = DATA_W'(ctrl_q);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      ctrl_q <= '0;
      rdata  <= '0;
    end else begin
      if (wr_en) begin
        for (int i = 0; i < N_CH; i++)
          if (addr == ADDR_W'(i * 4)) cnt_q[i] <= wdata;
        if (addr == CTRL_ADDR) ctrl_q <= wdata[CTRL_USED-1:0];
      end
      rdata <= rd_nx;
    end
  end

  assign cnt_o  = cnt_q;
  assign ctrl_o = ctrl_q;
endmodule

// File: rtl/dhp_clkpath.sv
module dhp_clkpath #(
  parameter int unsigned NUM_SRC = 4,
  parameter int unsigned SEL_W   = 2,
  parameter int unsigned DIV_W   = 7
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] src_tick,
  input  logic [SEL_W-1:0]   sel,
  input  logic [DIV_W-1:0]   div,
  input  logic               gate,
  output logic               tick
);
  logic             sel_tick;
  logic [DIV_W-1:0] div_cnt;
  logic             div_wrap;

  assign sel_tick = src_tick[sel];
  // >= so that lowering the divider mid-count never strands the counter
  assign div_wrap = (div_cnt >= div);

  always_ff @(posedge clk) begin
    if (rst)           div_cnt <= '0;
    else if (sel_tick) div_cnt <= div_wrap ? '0 : div_cnt + 1'b1;
  end

  assign tick = sel_tick & div_wrap & gate;
endmodule

// File: rtl/dhp_counter.sv
module dhp_counter #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             tick,
  input  logic [CNT_W-1:0] hi_in,
  input  logic [CNT_W-1:0] lo_in,
  output logic             pwm_o
);
  logic             en_q;
  logic             ph_hi;
  logic [CNT_W-1:0] cnt, sh_hi, sh_lo;
  logic [CNT_W:0]   cnt_nx;
  logic             hi_done, lo_done, boundary, to_lo;

  assign cnt_nx   = {1'b0, cnt} + 1'b1;
  assign hi_done  = cnt_nx >= {1'b0, sh_hi};
  assign lo_done  = cnt_nx >= {1'b0, sh_lo};
  assign boundary = tick & (ph_hi ? (hi_done & (sh_lo == '0)) : lo_done);
  assign to_lo    = tick & ph_hi & hi_done & (sh_lo != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q  <= 1'b0;
      ph_hi <= 1'b0;
      cnt   <= '0;
      sh_hi <= '0;
      sh_lo <= '0;
      pwm_o <= 1'b0;
    end else begin
      en_q <= en;
      if (!en) begin
        ph_hi <= 1'b0;
        cnt   <= '0;
        pwm_o <= 1'b0;
      end else if (!en_q || boundary) begin
        sh_hi <= hi_in;
        sh_lo <= lo_in;
        cnt   <= '0;
        ph_hi <= (hi_in != '0);
        pwm_o <= (hi_in != '0);
      end else if (to_lo) begin
        ph_hi <= 1'b0;
        cnt   <= '0;
        pwm_o <= 1'b0;
      end else if (tick) begin
        cnt <= cnt_nx[CNT_W-1:0];
      end
    end
  end
endmodule

// File: rtl/dual_hl_pwm.sv
module dual_hl_pwm
  import dhp_pkg::*;
#(
  parameter int unsigned ADDR_W  = 4,
  parameter int unsigned CNT_W   = 16,
  parameter int unsigned DIV_W   = 7,
  parameter int unsigned SEL_W   = 2,
  parameter int unsigned NUM_SRC = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] src_tick,
  input  logic               bus_wr,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [31:0]        bus_wdata,
  output logic [31:0]        bus_rdata,
  output logic [NUM_CH-1:0]  pwm_out
);
  logic [NUM_CH-1:0][DATA_W-1:0] cnt_w;
  logic [CTRL_USED-1:0]          ctrl_w;
  logic [NUM_CH-1:0]             ch_en;
  logic [NUM_CH-1:0]             ch_gate;
  logic                          ctrl_unused;

  dhp_regs #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .N_CH(NUM_CH), .CTRL_USED(CTRL_USED)
  ) u_regs (
    .clk(clk), .rst(rst), .wr_en(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
    .rdata(bus_rdata), .cnt_o(cnt_w), .ctrl_o(ctrl_w)
  );

  // bits between the enables and the first select are stored but drive nothing
  assign ctrl_unused = ^ctrl_w[SEL_BASE-1:NUM_CH];

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    localparam int unsigned SEL_LSB  = SEL_BASE + SEL_W * c;
    localparam int unsigned DIV_LSB  = DIV_BASE + DIV_STEP * c;
    localparam int unsigned GATE_BIT = GATE_BASE + DIV_STEP * c;

    logic [SEL_W-1:0] sel;
    logic [DIV_W-1:0] div;
    logic             tick;

    assign ch_en[c]   = ctrl_w[c];
    assign ch_gate[c] = ctrl_w[GATE_BIT];
    assign sel        = ctrl_w[SEL_LSB +: SEL_W];
    assign div        = ctrl_w[DIV_LSB +: DIV_W];

    dhp_clkpath #(.NUM_SRC(NUM_SRC), .SEL_W(SEL_W), .DIV_W(DIV_W)) u_clk (
      .clk(clk), .rst(rst), .src_tick(src_tick), .sel(sel), .div(div),
      .gate(ch_gate[c]), .tick(tick)
    );

    dhp_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst(rst), .en(ch_en[c]), .tick(tick),
      .hi_in(cnt_w[c][CNT_W +: CNT_W]), .lo_in(cnt_w[c][0 +: CNT_W]),
      .pwm_o(pwm_out[c])
    );
  end
endmodule

// File: rtl/dhp_chk.sv
module dhp_chk #(
  parameter int unsigned NCH    = 2,
  parameter int unsigned ADDR_W = 4
) (
  input logic              clk,
  input logic              rst,
  input logic [NCH-1:0]    ch_en,
  input logic [NCH-1:0]    ch_gate,
  input logic [NCH-1:0]    pwm_out,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       bus_rdata
);
  for (genvar i = 0; i < NCH; i++) begin : g_c
    // R8
    en_fall_low_chk: assert property (@(posedge clk) disable iff (rst)
      $fell(ch_en[i]) |=> !pwm_out[i]);
    // R8
    off_stays_low_chk: assert property (@(posedge clk) disable iff (rst)
      !ch_en[i] |=> !pwm_out[i]);
    // R10
    gate_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (ch_en[i] && $past(ch_en[i]) && !ch_gate[i]) |=> $stable(pwm_out[i]));
    // R3
    high_needs_en_chk: assert property (@(posedge clk) disable iff (rst)
      pwm_out[i] |-> $past(ch_en[i]));
  end

  // R2
  ctrl_top_zero_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(bus_addr) == ADDR_W'(8)) |-> (bus_rdata[31:24] == 8'h00));
endmodule

bind dual_hl_pwm dhp_chk #(.NCH(2), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .ch_en(ch_en), .ch_gate(ch_gate),
  .pwm_out(pwm_out), .bus_addr(bus_addr), .bus_rdata(bus_rdata)
);

// File: tb/sim_dual_hl_pwm.sv
`timescale 1ns/1ps
module sim_dual_hl_pwm;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  src_tick = '0;
  logic        bus_wr = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  wire  [31:0] bus_rdata;
  wire  [1:0]  pwm_out;

  always #2 clk = ~clk;

  dual_hl_pwm u0 (
    .clk(clk), .rst(rst), .src_tick(src_tick), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pwm_out(pwm_out)
  );

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  int src_phase = 0;

  // scoreboard
  int    exp_hi_q[$];
  int    exp_lo_q[$];
  string exp_tag_q[$];
  logic  mon_arm = 1'b0;
  logic  mon_synced = 1'b0;
  logic  mon_prev = 1'b0;
  logic  mon_cur;
  int    mon_ch = 0;
  int    mon_state = 0;
  int    hcnt = 0, lcnt = 0, mon_eh, mon_el;
  string mon_t;

  // sources: 0 every cycle, 1 every 2nd, 2 every 3rd, 3 grounded
  always @(negedge clk) begin
    src_phase <= src_phase + 1;
    src_tick  <= {1'b0, (src_phase % 3) == 0, (src_phase % 2) == 0, 1'b1};
  end

  task automatic check(string tag, int act, int expv, string what);
    checks++;
    if (act != expv) begin
      fails++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, expv);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual=%0d expected<150000", cyc);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  // monitor: measures high and low runs of the watched channel
  always @(negedge clk) begin
    if (!mon_arm) begin
      mon_state  = 0;
      mon_synced = 1'b0;
      mon_prev   = pwm_out[mon_ch];
    end else begin
      mon_cur = pwm_out[mon_ch];
      case (mon_state)
        0: if (mon_cur && !mon_prev) begin
             mon_state = 1; hcnt = 1; mon_synced = 1'b1;
           end
        1: if (mon_cur) hcnt++;
           else begin lcnt = 1; mon_state = 2; end
        default: if (!mon_cur) lcnt++;
           else begin
             if (exp_hi_q.size() > 0) begin
               mon_t  = exp_tag_q.pop_front();
               mon_eh = exp_hi_q.pop_front();
               mon_el = exp_lo_q.pop_front();
               check(mon_t, hcnt, mon_eh, "high run cycles");
               check(mon_t, lcnt, mon_el, "low run cycles");
             end
             hcnt = 1; mon_state = 1;
           end
      endcase
      mon_prev = mon_cur;
    end
  end

  task automatic wr(logic [3:0] a, logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
  endtask

  function automatic logic [31:0] cw(bit ea, bit eb, int sa, int sb,
                                     int da, int db, bit ga, bit gb);
    logic [31:0] v;
    v = '0;
    v[0] = ea; v[1] = eb;
    v[5:4] = sa[1:0]; v[7:6] = sb[1:0];
    v[14:8] = da[6:0]; v[15] = ga;
    v[22:16] = db[6:0]; v[23] = gb;
    return v;
  endfunction

  task automatic push_exp(string tag, int h, int l);
    exp_tag_q.push_back(tag);
    exp_hi_q.push_back(h);
    exp_lo_q.push_back(l);
  endtask

  task automatic drain(string tag);
    int t = 0;
    while (exp_hi_q.size() > 0 && t < 3000) begin
      @(posedge clk); t++;
    end
    if (exp_hi_q.size() > 0) begin
      checks++; fails++;
      $display("FAIL %s monitor timeout: actual=%0d pending expected=0", tag, exp_hi_q.size());
      exp_hi_q.delete(); exp_lo_q.delete(); exp_tag_q.delete();
    end
    @(posedge clk);
    mon_arm = 1'b0;
  endtask

  task automatic expect_wave(string tag, int ch, int h, int l, int n);
    @(posedge clk);
    mon_ch = ch;
    for (int k = 0; k < n; k++) push_exp(tag, h, l);
    @(posedge clk);
    mon_arm = 1'b1;
    drain(tag);
  endtask

  task automatic wait_rise(int ch);
    int t = 0;
    @(negedge clk);
    while (pwm_out[ch] && t < 2000) begin @(negedge clk); t++; end
    while (!pwm_out[ch] && t < 2000) begin @(negedge clk); t++; end
  endtask

  task automatic count_level(int ch, int n, bit lvl, output int hits);
    hits = 0;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      if (pwm_out[ch] == lvl) hits++;
    end
  endtask

  initial begin
    logic [31:0] d;
    int hits;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    check("R1", int'(pwm_out), 0, "outputs after reset");
    rd(4'h0, d); check("R1", d, 0, "count A after reset");
    rd(4'h4, d); check("R1", d, 0, "count B after reset");
    rd(4'h8, d); check("R1", d, 0, "control after reset");

    // R2 readback
    wr(4'h0, 32'h0003_0005);
    wr(4'h4, 32'h0002_0004);
    wr(4'h8, 32'hFF00_0000);
    rd(4'h0, d); check("R2", d, 32'h0003_0005, "count A readback");
    rd(4'h4, d); check("R2", d, 32'h0002_0004, "count B readback");
    rd(4'h8, d); check("R2", d, 0, "control upper bits masked");

    // R3 basic wave, R4 layout readback
    wr(4'h8, cw(1, 0, 0, 0, 0, 0, 1, 0));
    rd(4'h8, d); check("R4", d, 32'h0000_8001, "control field layout");
    expect_wave("R3", 0, 3, 5, 3);

    // R6 divider 2 on every-cycle source
    wr(4'h8, cw(1, 0, 0, 0, 2, 0, 1, 0));
    expect_wave("R6", 0, 9, 15, 2);

    // R5 source select
    wr(4'h8, cw(1, 0, 2, 0, 0, 0, 1, 0));
    expect_wave("R5", 0, 9, 15, 2);
    wr(4'h8, cw(1, 0, 1, 0, 1, 0, 1, 0));
    expect_wave("R5", 0, 12, 20, 2);

    // R11 both channels together
    wr(4'h8, cw(1, 1, 0, 1, 0, 0, 1, 1));
    rd(4'h8, d); check("R4", d, 32'h0080_8043, "control both channels");
    expect_wave("R11", 1, 4, 8, 2);
    expect_wave("R11", 0, 3, 5, 2);

    // R9 count change waits for the period boundary
    @(posedge clk);
    mon_ch = 0;
    push_exp("R9", 3, 5);
    push_exp("R9", 6, 2);
    @(posedge clk);
    mon_arm = 1'b1;
    while (!mon_synced) @(posedge clk);
    wr(4'h0, 32'h0006_0002);
    drain("R9");

    // R7 zero lengths
    wr(4'h0, 32'h0000_0005);
    repeat (40) @(negedge clk);
    count_level(0, 60, 1'b1, hits); check("R7", hits, 0, "high samples with zero high length");
    wr(4'h0, 32'h0004_0000);
    repeat (40) @(negedge clk);
    count_level(0, 60, 1'b0, hits); check("R7", hits, 0, "low samples with zero low length");

    // R10 gate hold
    wr(4'h0, 32'h0014_0014);
    wait_rise(0);
    wr(4'h8, cw(1, 1, 0, 1, 0, 0, 0, 1));
    count_level(0, 50, 1'b0, hits); check("R10", hits, 0, "low samples while gated");
    wr(4'h8, cw(1, 1, 0, 1, 0, 0, 1, 1));
    count_level(0, 100, 1'b0, hits); check("R10", int'(hits > 0), 1, "wave resumes after ungate");

    // R5 grounded source freezes level
    wait_rise(0);
    wr(4'h8, cw(1, 1, 3, 1, 0, 0, 1, 1));
    count_level(0, 60, 1'b0, hits); check("R5", hits, 0, "low samples on grounded source");
    wr(4'h8, cw(1, 1, 0, 1, 0, 0, 1, 1));

    // R8 immediate disable during high part
    wait_rise(0);
    wr(4'h8, cw(0, 1, 0, 1, 0, 0, 1, 1));
    @(negedge clk); check("R8", int'(pwm_out[0]), 0, "A low one edge after disable");
    count_level(0, 40, 1'b1, hits); check("R8", hits, 0, "A stays low while disabled");

    // R9 enable rise restarts high
    wr(4'h8, cw(1, 1, 0, 1, 0, 0, 1, 1));
    @(negedge clk); check("R9", int'(pwm_out[0]), 1, "A high one edge after enable");

    // R8 channel B disable, R11 A unaffected
    wait_rise(1);
    wr(4'h8, cw(1, 0, 0, 1, 0, 0, 1, 1));
    @(negedge clk); check("R8", int'(pwm_out[1]), 0, "B low after disable");
    wr(4'h0, 32'h0003_0005);
    expect_wave("R11", 0, 3, 5, 2);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule